// File: doc/BRIEF.md
# Real-Time Clock Control and Interrupt Section

This block holds the control byte of a real-time clock and produces the clock's event flags, its interrupt request and its square-wave output. Software reaches it through a byte-wide register bus with two addresses: the control byte and the flag byte. The time counters and the rate divider sit outside. The counters receive an update-hold signal and the number-format selects. The divider supplies a periodic tick and a rate clock.

Three events set flags. A periodic tick sets the periodic flag. A completed once-per-second update sets the update-ended flag. A time that matches the alarm on the cycle after an update sets the alarm flag. Any alarm byte with its two top bits both 1 matches every value. Each flag pulls the active-low interrupt line only while its own enable is set. One read of the flag byte clears all three flags.

Each control bit follows its own reset rule. The hold, format and daylight bits keep their value through reset. The four enables clear on reset. Setting the hold bit also clears the update-ended enable.

Top module: `rtc_ctl_irq`

## Requirements
- R1: Synchronous reset (`rst` high) clears control bits 6 to 3 and all three event flags, so `irq_n` is 1 and `sqw_out` is 0 after the reset edge.
- R2: The control byte at address `CTRL_ADDR` (default 0) reads back as written, with fields bit7 hold, bit6 periodic enable, bit5 alarm enable, bit4 update-ended enable, bit3 square-wave enable, bit2 binary mode, bit1 24-hour mode and bit0 daylight enable. Reset leaves bits 7, 2, 1 and 0 unchanged.
- R3: A write that changes bit 7 from 0 to 1 stores bit 4 as 0, whatever `wdata[4]` holds. A write while bit 7 is already 1 stores `wdata[4]` as given.
- R4: `upd_inhibit` equals control bit 7. A `sec_tick` that arrives while bit 7 is 1 sets neither the update-ended flag nor the alarm flag.
- R5: A `sec_tick` sampled while bit 7 is 0 sets the update-ended flag (flag byte bit 4) two clock edges later.
- R6: A `per_tick` sets the periodic flag (flag byte bit 6) at the next edge, whatever the value of the periodic enable.
- R7: On the cycle after an accepted update, the alarm flag (flag byte bit 5) is set if each of the seconds, minutes and hours alarm bytes equals its time byte or has bits 7:6 equal to 2'b11.
- R8: `irq_n` is 0 exactly when (periodic flag and bit 6), (alarm flag and bit 5) or (update-ended flag and bit 4) holds. Flag byte bit 7 reads as the inverse of `irq_n`, and bits 3:0 read as 0.
- R9: The flag byte reads at address `FLAG_ADDR` (default 1). An edge with `rd_en` high at that address clears all flags. An event in that same cycle still sets its own flag.
- R10: `sqw_out` is registered and equals (control bit 3 AND `rate_clk`) as sampled at the previous edge.
- R11: `bin_mode` follows control bit 2 and `hr24_mode` follows control bit 1. Any other address reads as 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at FLAG_ADDR) |
| addr | input | ADDR_W | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| sec_tick | input | 1 | Once-per-second update strobe |
| per_tick | input | 1 | Periodic tick from the rate divider |
| rate_clk | input | 1 | Rate-divider clock for the square wave |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hr | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hr | input | 8 | Alarm hours byte |
| irq_n | output | 1 | Interrupt request, active low |
| sqw_out | output | 1 | Square-wave output |
| upd_inhibit | output | 1 | Hold signal for the time counters |
| bin_mode | output | 1 | 1 = binary, 0 = BCD |
| hr24_mode | output | 1 | 1 = 24-hour, 0 = 12-hour |

## Verification
The assertions assume that `sec_tick`, `per_tick` and the strobes are single-cycle levels sampled at the clock edge. They also assume that the time bytes have already taken their post-update value by the cycle after the tick. The bench drives every input once per cycle, just after the falling edge. It holds `sec_tick` low until the control byte has been written once, so that the hold bit, which reset leaves alone, is known. The random phase biases the alarm bytes toward equal or wildcard values so that both match and mismatch occur often.

// File: rtl/rtc_ctl_pkg.sv
package rtc_ctl_pkg;

    localparam int BYTE_W     = 8;
    localparam int TIME_BYTES = 3;
    localparam logic [1:0] WILD_CODE = 2'b11;

    // control byte, MSB first
    typedef struct packed {
        logic upd_hold;
        logic per_en;
        logic alm_en;
        logic upd_en;
        logic sqw_en;
        logic bin_mode;
        logic hr24_mode;
        logic dst_en;
    } ctrl_t;

    typedef struct packed {
        logic per_f;
        logic alm_f;
        logic upd_f;
    } evt_t;

    function automatic logic byte_matches(logic [BYTE_W-1:0] now_b,
                                          logic [BYTE_W-1:0] alm_b);
        return (alm_b[BYTE_W-1 -: 2] == WILD_CODE) || (alm_b == now_b);
    endfunction

    function automatic logic [BYTE_W-1:0] flag_byte(evt_t e, logic any_irq);
        return {any_irq, e.per_f, e.alm_f, e.upd_f, 4'b0000};
    endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg
    import rtc_ctl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_t             ctrl_q
);

    localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

    ctrl_t nxt;
    logic  hit;

    assign hit = wr_en && (addr == SEL);

    always_comb begin
        nxt = ctrl_t'(wdata);
        // entering hold mode drops the update-ended enable
        if (nxt.upd_hold && !ctrl_q.upd_hold)
            nxt.upd_en = 1'b0;
    end

    // hold, format and daylight bits carry no reset
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.per_en <= 1'b0;
            ctrl_q.alm_en <= 1'b0;
            ctrl_q.upd_en <= 1'b0;
            ctrl_q.sqw_en <= 1'b0;
        end else if (hit) begin
            ctrl_q <= nxt;
        end
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_ctl_pkg::*;
#(
    parameter int N = TIME_BYTES
) (
    input  logic [N-1:0][BYTE_W-1:0] now_b,
    input  logic [N-1:0][BYTE_W-1:0] alm_b,
    output logic                     all_hit
);

    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_byte
        assign hit[i] = byte_matches(now_b[i], alm_b[i]);
    end

    assign all_hit = &hit;

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
    import rtc_ctl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  sec_tick,
    input  logic  per_tick,
    input  logic  alarm_hit,
    input  logic  clr,
    output logic  upd_done,
    output evt_t  flags_q,
    output logic  irq_req
);

    evt_t nxt;

    always_comb begin
        nxt = clr ? '0 : flags_q;
        // a new event outranks the read-clear
        if (per_tick)              nxt.per_f = 1'b1;
        if (upd_done)              nxt.upd_f = 1'b1;
        if (upd_done && alarm_hit) nxt.alm_f = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_done <= 1'b0;
            flags_q  <= '0;
        end else begin
            upd_done <= sec_tick && !ctrl.upd_hold;
            flags_q  <= nxt;
        end
    end

    assign irq_req = (flags_q.per_f && ctrl.per_en)
                  || (flags_q.alm_f && ctrl.alm_en)
                  || (flags_q.upd_f && ctrl.upd_en);

endmodule

// File: rtl/rtc_ctl_irq.sv
module rtc_ctl_irq
    import rtc_ctl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int CTRL_ADDR = 0,
    parameter int FLAG_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              sec_tick,
    input  logic              per_tick,
    input  logic              rate_clk,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hr,
    input  logic [7:0]        alm_sec,
    input  logic [7:0]        alm_min,
    input  logic [7:0]        alm_hr,
    output logic              irq_n,
    output logic              sqw_out,
    output logic              upd_inhibit,
    output logic              bin_mode,
    output logic              hr24_mode
);

    localparam logic [ADDR_W-1:0] C_SEL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] F_SEL = ADDR_W'(FLAG_ADDR);

    ctrl_t ctrl_q;
    evt_t  flags_q;
    logic  irq_req;
    logic  upd_done;
    logic  alarm_hit;
    logic  flag_clr;
    logic [TIME_BYTES-1:0][BYTE_W-1:0] now_v;
    logic [TIME_BYTES-1:0][BYTE_W-1:0] alm_v;

    assign now_v    = {cur_hr, cur_min, cur_sec};
    assign alm_v    = {alm_hr, alm_min, alm_sec};
    assign flag_clr = rd_en && (addr == F_SEL);

    rtc_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .ctrl_q (ctrl_q)
    );

    rtc_alarm_cmp #(.N(TIME_BYTES)) u_cmp (
        .now_b   (now_v),
        .alm_b   (alm_v),
        .all_hit (alarm_hit)
    );

    rtc_event_flags u_evt (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .sec_tick  (sec_tick),
        .per_tick  (per_tick),
        .alarm_hit (alarm_hit),
        .clr       (flag_clr),
        .upd_done  (upd_done),
        .flags_q   (flags_q),
        .irq_req   (irq_req)
    );

    always_ff @(posedge clk) begin
        if (rst) sqw_out <= 1'b0;
        else     sqw_out <= ctrl_q.sqw_en && rate_clk;
    end

    always_comb begin
        if (addr == C_SEL)      rdata = ctrl_q;
        else if (addr == F_SEL) rdata = flag_byte(flags_q, irq_req);
        else                    rdata = '0;
    end

    assign irq_n       = !irq_req;
    assign upd_inhibit = ctrl_q.upd_hold;
    assign bin_mode    = ctrl_q.bin_mode;
    assign hr24_mode   = ctrl_q.hr24_mode;

endmodule

// File: rtl/rtc_ctl_irq_chk.sv
module rtc_ctl_irq_chk
    import rtc_ctl_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int FLAG_ADDR = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              sec_tick,
    input logic              per_tick,
    input logic              upd_inhibit,
    input logic              upd_done,
    input logic              irq_n,
    input logic              sqw_out,
    input ctrl_t             ctrl_q,
    input evt_t              flags_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!ctrl_q.per_en && !ctrl_q.alm_en && !ctrl_q.upd_en && !ctrl_q.sqw_en && irq_n));

    // R3
    hold_drops_upd_en_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.upd_hold) |-> !ctrl_q.upd_en);

    // R4
    hold_blocks_update_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_tick && upd_inhibit) |=> !upd_done);

    // R5
    update_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        upd_done |=> flags_q.upd_f);

    // R6
    periodic_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        per_tick |=> flags_q.per_f);

    // R8
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> (flags_q != '0));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == ADDR_W'(FLAG_ADDR) && !per_tick) |=> !flags_q.per_f);

    // R10
    sqw_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.sqw_en |=> !sqw_out);

endmodule

bind rtc_ctl_irq rtc_ctl_irq_chk #(.ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_en       (rd_en),
    .addr        (addr),
    .sec_tick    (sec_tick),
    .per_tick    (per_tick),
    .upd_inhibit (upd_inhibit),
    .upd_done    (upd_done),
    .irq_n       (irq_n),
    .sqw_out     (sqw_out),
    .ctrl_q      (ctrl_q),
    .flags_q     (flags_q)
);

// File: tb/rtc_ctl_irq_test.sv
module rtc_ctl_irq_test;
    import rtc_ctl_pkg::*;

    localparam int CLK_P = 10;
    localparam int AW    = 2;

    logic clk = 1'b0;
    logic rst, wr_en, rd_en, sec_tick, per_tick, rate_clk;
    logic [AW-1:0] addr;
    logic [7:0] wdata, rdata;
    logic [7:0] cur_sec, cur_min, cur_hr, alm_sec, alm_min, alm_hr;
    logic irq_n, sqw_out, upd_inhibit, bin_mode, hr24_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    ctrl_t m_ctrl;
    evt_t  m_flags;
    logic  m_upd, m_sqw;
    bit    m_known = 0;

    always #(CLK_P/2) clk = ~clk;

    rtc_ctl_irq #(.ADDR_W(AW)) uut (.*);

    task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic m_irq();
        return (m_flags.per_f && m_ctrl.per_en) || (m_flags.alm_f && m_ctrl.alm_en)
            || (m_flags.upd_f && m_ctrl.upd_en);
    endfunction

    function automatic logic m_match();
        return byte_matches(cur_sec, alm_sec) && byte_matches(cur_min, alm_min)
            && byte_matches(cur_hr, alm_hr);
    endfunction

    task automatic idle();
        wr_en = 0; rd_en = 0; sec_tick = 0; per_tick = 0;
    endtask

    // compare, predict, clock, commit
    task automatic step();
        ctrl_t nc; evt_t nf; logic nu, ns;
        logic [7:0] er;
        #1;
        chk(irq_n == !m_irq(), "R8 irq_n", {7'd0, irq_n}, {7'd0, !m_irq()});
        chk(sqw_out == m_sqw, "R10 sqw_out", {7'd0, sqw_out}, {7'd0, m_sqw});
        if (addr == 2'd1) begin
            er = flag_byte(m_flags, m_irq());
            chk(rdata == er, "R9 flag byte", rdata, er);
        end else if (addr != 2'd0) begin
            chk(rdata == 8'h00, "R11 unmapped read", rdata, 8'h00);
        end else if (m_known) begin
            chk(rdata == m_ctrl, "R2 control byte", rdata, m_ctrl);
        end
        if (m_known) begin
            chk(upd_inhibit == m_ctrl.upd_hold, "R4 upd_inhibit", {7'd0, upd_inhibit}, {7'd0, m_ctrl.upd_hold});
            chk({bin_mode, hr24_mode} == {m_ctrl.bin_mode, m_ctrl.hr24_mode}, "R11 format outs",
                {6'd0, bin_mode, hr24_mode}, {6'd0, m_ctrl.bin_mode, m_ctrl.hr24_mode});
        end
        nc = m_ctrl; nf = m_flags; nu = m_upd; ns = m_sqw;
        if (rst) begin
            nc.per_en = 0; nc.alm_en = 0; nc.upd_en = 0; nc.sqw_en = 0;
            nf = '0; nu = 0; ns = 0;
        end else begin
            if (wr_en && addr == 2'd0) begin
                nc = ctrl_t'(wdata);
                if (nc.upd_hold && !m_ctrl.upd_hold) nc.upd_en = 0;
            end
            if (rd_en && addr == 2'd1) nf = '0;
            if (per_tick) nf.per_f = 1;
            if (m_upd) nf.upd_f = 1;
            if (m_upd && m_match()) nf.alm_f = 1;
            nu = sec_tick && !m_ctrl.upd_hold;
            ns = m_ctrl.sqw_en && rate_clk;
        end
        @(posedge clk);
        #1;
        m_ctrl = nc; m_flags = nf; m_upd = nu; m_sqw = ns;
        if (!rst && wr_en && addr == 2'd0) m_known = 1;
        @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        idle(); wr_en = 1; addr = 0; wdata = v; step(); idle();
    endtask

    task automatic peek(logic [AW-1:0] a, output logic [7:0] v);
        addr = a; #1; v = rdata;
    endtask

    task automatic set_time(logic [7:0] h, m, s, ah, am, as_);
        cur_hr = h; cur_min = m; cur_sec = s; alm_hr = ah; alm_min = am; alm_sec = as_;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        m_ctrl = '0; m_flags = '0; m_upd = 0; m_sqw = 0;
        idle(); rate_clk = 0; addr = 0; wdata = 0;
        set_time(8'h12, 8'h34, 8'h56, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        rst = 1; step(); step(); rst = 0;

        // R1 reset state
        peek(1, v);
        chk(v == 8'h00, "R1 flags after reset", v, 8'h00);
        chk(irq_n == 1'b1 && sqw_out == 1'b0, "R1 irq_n/sqw after reset", {6'd0, irq_n, sqw_out}, 8'h02);

        // R2 readback and format outputs
        wr_ctrl(8'h7E);
        peek(0, v);
        chk(v == 8'h7E, "R2 readback", v, 8'h7E);
        chk(bin_mode && hr24_mode, "R11 format outs", {6'd0, bin_mode, hr24_mode}, 8'h03);

        // R1/R2 reset keeps format bits, clears enables
        rst = 1; step(); rst = 0;
        peek(0, v);
        chk(v == 8'h06, "R1 R2 reset rule", v, 8'h06);

        // R3 hold entry clears update-ended enable
        wr_ctrl(8'h10);
        wr_ctrl(8'h90);
        peek(0, v);
        chk(v == 8'h80, "R3 hold entry", v, 8'h80);
        wr_ctrl(8'h90);
        peek(0, v);
        chk(v == 8'h90, "R3 hold kept", v, 8'h90);

        // R4 tick under hold does nothing
        set_time(8'h12, 8'h34, 8'h56, 8'h12, 8'h34, 8'h56);
        chk(upd_inhibit == 1'b1, "R4 inhibit high", {7'd0, upd_inhibit}, 8'h01);
        sec_tick = 1; step(); idle(); step(); step();
        peek(1, v);
        chk(v == 8'h00, "R4 no flag under hold", v, 8'h00);

        // R5 update-ended timing, R7 exact alarm
        wr_ctrl(8'h10);
        sec_tick = 1; step(); idle();
        peek(1, v);
        chk(v[4] == 1'b0, "R5 not yet", v, 8'h00);
        step();
        peek(1, v);
        chk(v == 8'hB0, "R5 R7 update and alarm", v, 8'hB0);
        chk(irq_n == 1'b0, "R8 upd irq", {7'd0, irq_n}, 8'h00);

        // R9 read clears
        addr = 1; rd_en = 1; step(); idle();
        peek(1, v);
        chk(v == 8'h00, "R9 cleared", v, 8'h00);

        // R6 periodic flag with enable off, then on
        wr_ctrl(8'h00);
        per_tick = 1; step(); idle();
        peek(1, v);
        chk(v == 8'h40 && irq_n, "R6 flag without irq", v, 8'h40);
        wr_ctrl(8'h40);
        chk(irq_n == 1'b0, "R8 periodic irq", {7'd0, irq_n}, 8'h00);

        // R9 event during clear survives
        addr = 1; rd_en = 1; per_tick = 1; step(); idle();
        peek(1, v);
        chk(v == 8'hC0, "R9 event beats clear", v, 8'hC0);

        // R7 wildcard hours match, minutes mismatch blocks
        addr = 1; rd_en = 1; step(); idle();
        set_time(8'h07, 8'h34, 8'h56, 8'hC0, 8'h34, 8'h56);
        sec_tick = 1; step(); idle(); step();
        peek(1, v);
        chk(v[5] == 1'b1, "R7 wildcard match", v, 8'h30);
        addr = 1; rd_en = 1; step(); idle();
        set_time(8'h07, 8'h34, 8'h56, 8'hC0, 8'h35, 8'h56);
        sec_tick = 1; step(); idle(); step();
        peek(1, v);
        chk(v[5] == 1'b0, "R7 mismatch", v, 8'h10);

        // R10 square wave follows rate clock
        wr_ctrl(8'h08);
        rate_clk = 1; step();
        chk(sqw_out == 1'b1, "R10 sqw high", {7'd0, sqw_out}, 8'h01);
        rate_clk = 0; step();
        chk(sqw_out == 1'b0, "R10 sqw low", {7'd0, sqw_out}, 8'h00);

        // R11 unmapped write ignored
        wr_en = 1; addr = 3; wdata = 8'hFF; step(); idle();
        peek(0, v);
        chk(v == 8'h08, "R11 unmapped write", v, 8'h08);

        // random phase checked against the model
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] t;
            idle();
            rate_clk = $urandom_range(0, 1);
            per_tick = ($urandom_range(0, 7) == 0);
            sec_tick = ($urandom_range(0, 5) == 0);
            addr     = AW'($urandom_range(0, 3));
            if ($urandom_range(0, 9) == 0) begin
                wr_en = 1; addr = 0; wdata = 8'($urandom);
            end else if ($urandom_range(0, 5) == 0) begin
                rd_en = 1; addr = 1;
            end
            if ($urandom_range(0, 3) == 0) begin
                cur_sec = 8'($urandom); cur_min = 8'($urandom); cur_hr = 8'($urandom);
            end
            t = 8'($urandom);
            alm_sec = (t[1:0] == 0) ? 8'hC5 : (t[1:0] == 1) ? 8'($urandom) : cur_sec;
            alm_min = (t[3:2] == 0) ? 8'hFF : (t[3:2] == 1) ? 8'($urandom) : cur_min;
            alm_hr  = (t[5:4] == 0) ? 8'hC0 : (t[5:4] == 1) ? 8'($urandom) : cur_hr;
            rst = ($urandom_range(0, 499) == 0);
            step();
            rst = 0;
        end
        idle();
        step();
        finish_run();
    end

endmodule